// File: doc/BRIEF.md
# Operand Address Sequencer

This unit turns a decoded operand specifier into a ready operand and, where one exists, the address it came from. A specifier carries a 3-bit mode, a register index, an auto-increment flag and a 16-bit constant. On a start pulse the unit latches the specifier, the selected register value, the program counter and the stack pointer. It then issues as many memory reads as the mode needs, one at a time, over a request/valid handshake. When the result is ready it raises `done` for one cycle, together with the effective address, the operand and an error flag. In the same cycle it may raise a register write-back strobe that carries an incremented index register.

The controller has four states. IDLE waits for `start`. On `start` it takes one of three transitions, chosen by the mode: *no-fetch* goes to DONE, *chase* goes to PTR and *fetch* goes to OPND. PTR holds a pointer read. When the read completes it takes one of three transitions: *follow* loops back to PTR for another level, *resolve* goes to OPND, and *overflow* goes to DONE with the error flag set. OPND holds the operand read, and its *loaded* transition goes to DONE. DONE always returns to IDLE through the *retire* transition.

Mode codes: 0 literal, 1 absolute, 2 memory-indirect, 3 register, 4 register-pointer, 5 base-plus-offset, 6 pc-relative, 7 stack-top.

Top module: `ea_gen_unit`

## Requirements
- R1: In mode 0 (literal), `operand` equals the constant and `ea` is 0. No memory read is issued.
- R2: In mode 1 (absolute), `ea` equals the constant. Exactly one read, at that address, supplies `operand`.
- R3: In mode 2 (memory-indirect), the word read at the constant becomes `ea` when its bit 15 is clear. A second read at `ea` then supplies `operand`.
- R4: In mode 2, a pointer word with bit 15 set causes another pointer read at its lower 15 bits (bit 15 forced to 0). Each level costs one read.
- R5: In mode 2, if the fourth pointer word still has bit 15 set, no operand read follows. `ind_err` is raised with `done`, and `ea` and `operand` are both 0.
- R6: In mode 3 (register), `operand` is the selected register value and `ea` is 0. No memory read is issued.
- R7: In mode 4 (register-pointer), `ea` is the selected register value. One read there supplies `operand`.
- R8: In mode 5, `ea` is the constant plus the selected register, modulo 2^16. One read supplies `operand`.
- R9: In mode 6, `ea` is the constant plus `pc`, modulo 2^16. One read supplies `operand`.
- R10: In mode 7, `ea` is `sp_value`. One read there supplies `operand`.
- R11: With `spec_auto` set, modes 4 and 5 pulse `rf_wr_en` together with `done`. The write carries the selected index and that register's value plus 1, modulo 2^16. In every other mode the flag has no effect and `rf_wr_en` stays low.
- R12: `done` lasts exactly one cycle per accepted start. A `start` seen while the unit is busy, including the DONE cycle, is ignored.
- R13: `mem_req` stays high, with `mem_addr` unchanged, until a cycle in which `mem_valid` is high. `mem_rdata` is taken in that cycle.
- R14: After reset, `done`, `mem_req`, `rf_wr_en` and `ind_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one specifier; accepted only in IDLE |
| spec_mode | input | 3 | Mode code |
| spec_reg | input | 3 | Register index |
| spec_auto | input | 1 | Post-increment the index register |
| spec_field | input | 16 | Constant / address field |
| pc | input | 16 | Current program counter |
| sp_value | input | 16 | Stack pointer value |
| rf_rd_idx | output | 3 | Register read index (combinational read) |
| rf_rd_data | input | 16 | Register read data |
| rf_wr_en | output | 1 | Write-back strobe |
| rf_wr_idx | output | 3 | Write-back index |
| rf_wr_data | output | 16 | Write-back value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| done | output | 1 | Result ready, one cycle |
| ea | output | 16 | Effective address |
| operand | output | 16 | Operand value |
| ind_err | output | 1 | Indirection depth exceeded |

## Verification
The assertions assume that `mem_valid` is raised only while `mem_req` is high, for a single cycle per request. They also assume that `rf_rd_data` reflects `rf_rd_idx` combinationally in the same cycle. The bench's memory responder answers only open requests. It drops `mem_valid` for at least one cycle after every beat and inserts a rotating 0 to 2 cycle wait. The register model is a plain array indexed by `rf_rd_idx`. A start issued while the unit is busy comes with a different mode, which shows at the ports that it was dropped.

// File: rtl/eagu_pkg.sv
package eagu_pkg;

    typedef enum logic [2:0] {
        MD_LIT  = 3'd0,
        MD_ABS  = 3'd1,
        MD_MIND = 3'd2,
        MD_REG  = 3'd3,
        MD_RPTR = 3'd4,
        MD_BOFS = 3'd5,
        MD_PREL = 3'd6,
        MD_STK  = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PTR  = 2'd1,
        ST_OPND = 2'd2,
        ST_DONE = 2'd3
    } state_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_PTR  = 2'd1,
        ACT_OPND = 2'd2
    } act_e;

endpackage

// File: rtl/eagu_base_sel.sv
module eagu_base_sel
    import eagu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  mode_e              mode,
    input  logic               auto_inc,
    input  logic [WORD_W-1:0]  field,
    input  logic [WORD_W-1:0]  regval,
    input  logic [WORD_W-1:0]  pc,
    input  logic [WORD_W-1:0]  sp,
    output act_e               first_act,
    output logic [WORD_W-1:0]  base_addr,
    output logic [WORD_W-1:0]  direct_val,
    output logic               wb_ok
);

    always_comb begin
        first_act  = ACT_OPND;
        base_addr  = '0;
        direct_val = '0;
        unique case (mode)
            MD_LIT:  begin first_act = ACT_NONE; direct_val = field;  end
            MD_ABS:  base_addr = field;
            MD_MIND: begin first_act = ACT_PTR;  base_addr = field;   end
            MD_REG:  begin first_act = ACT_NONE; direct_val = regval; end
            MD_RPTR: base_addr = regval;
            MD_BOFS: base_addr = field + regval;
            MD_PREL: base_addr = field + pc;
            MD_STK:  base_addr = sp;
        endcase
    end

    assign wb_ok = auto_inc && ((mode == MD_RPTR) || (mode == MD_BOFS));

endmodule

// File: rtl/eagu_ptr_decode.sv
module eagu_ptr_decode #(
    parameter int WORD_W     = 16,
    parameter int MAX_LEVELS = 4,
    localparam int LVL_W     = $clog2(MAX_LEVELS + 1)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [LVL_W-1:0]  level,
    output logic              follow,
    output logic              overflow,
    output logic [WORD_W-1:0] next_addr
);

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(MAX_LEVELS - 1);

    logic chained;

    assign chained   = word[WORD_W-1];
    assign follow    = chained && (level < LAST_LVL);
    assign overflow  = chained && (level >= LAST_LVL);
    assign next_addr = {1'b0, word[WORD_W-2:0]};

endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
    import eagu_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int REG_COUNT  = 8,
    parameter int MAX_LEVELS = 4,
    localparam int IDX_W     = $clog2(REG_COUNT),
    localparam int LVL_W     = $clog2(MAX_LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        spec_mode,
    input  logic [IDX_W-1:0]  spec_reg,
    input  logic              spec_auto,
    input  logic [WORD_W-1:0] spec_field,
    input  logic [WORD_W-1:0] pc,
    input  logic [WORD_W-1:0] sp_value,
    output logic [IDX_W-1:0]  rf_rd_idx,
    input  logic [WORD_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [IDX_W-1:0]  rf_wr_idx,
    output logic [WORD_W-1:0] rf_wr_data,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [WORD_W-1:0] ea,
    output logic [WORD_W-1:0] operand,
    output logic              ind_err
);

    state_e             state, state_nxt;
    logic               busy;
    logic [IDX_W-1:0]   idx_q;
    logic [WORD_W-1:0]  addr_q;
    logic [WORD_W-1:0]  ea_q;
    logic [WORD_W-1:0]  opnd_q;
    logic [WORD_W-1:0]  wb_data_q;
    logic [LVL_W-1:0]   lvl_q;
    logic               wb_q;
    logic               err_q;

    act_e               first_act;
    logic [WORD_W-1:0]  base_addr;
    logic [WORD_W-1:0]  direct_val;
    logic               wb_ok;
    logic               ptr_follow;
    logic               ptr_overflow;
    logic [WORD_W-1:0]  ptr_next;

    assign rf_rd_idx = (state == ST_IDLE) ? spec_reg : idx_q;
    assign busy      = (state != ST_IDLE);

    eagu_base_sel #(.WORD_W(WORD_W)) u_base (
        .mode       (mode_e'(spec_mode)),
        .auto_inc   (spec_auto),
        .field      (spec_field),
        .regval     (rf_rd_data),
        .pc         (pc),
        .sp         (sp_value),
        .first_act  (first_act),
        .base_addr  (base_addr),
        .direct_val (direct_val),
        .wb_ok      (wb_ok)
    );

    eagu_ptr_decode #(.WORD_W(WORD_W), .MAX_LEVELS(MAX_LEVELS)) u_ptr (
        .word      (mem_rdata),
        .level     (lvl_q),
        .follow    (ptr_follow),
        .overflow  (ptr_overflow),
        .next_addr (ptr_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    unique case (first_act)
                        ACT_NONE: state_nxt = ST_DONE;  // no-fetch
                        ACT_PTR:  state_nxt = ST_PTR;   // chase
                        default:  state_nxt = ST_OPND;  // fetch
                    endcase
                end
            end
            ST_PTR: begin
                if (mem_valid) begin
                    if (ptr_overflow)    state_nxt = ST_DONE;  // overflow
                    else if (ptr_follow) state_nxt = ST_PTR;   // follow
                    else                 state_nxt = ST_OPND;  // resolve
                end
            end
            ST_OPND: if (mem_valid) state_nxt = ST_DONE;       // loaded
            ST_DONE: state_nxt = ST_IDLE;                      // retire
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            addr_q    <= '0;
            ea_q      <= '0;
            opnd_q    <= '0;
            wb_data_q <= '0;
            lvl_q     <= '0;
            wb_q      <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        idx_q     <= spec_reg;
                        wb_q      <= wb_ok;
                        wb_data_q <= rf_rd_data + WORD_W'(1);
                        err_q     <= 1'b0;
                        lvl_q     <= '0;
                        addr_q    <= base_addr;
                        opnd_q    <= direct_val;
                        ea_q      <= (first_act == ACT_OPND) ? base_addr : '0;
                    end
                end
                ST_PTR: begin
                    if (mem_valid) begin
                        if (ptr_overflow) begin
                            err_q  <= 1'b1;
                            ea_q   <= '0;
                            opnd_q <= '0;
                        end else begin
                            addr_q <= ptr_next;
                            lvl_q  <= lvl_q + LVL_W'(1);
                            if (!ptr_follow) ea_q <= ptr_next;
                        end
                    end
                end
                ST_OPND: if (mem_valid) opnd_q <= mem_rdata;
                ST_DONE: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done       = (state == ST_DONE);
        mem_req    = (state == ST_PTR) || (state == ST_OPND);
        mem_addr   = addr_q;
        ea         = ea_q;
        operand    = opnd_q;
        ind_err    = done && err_q;
        rf_wr_en   = done && wb_q;
        rf_wr_idx  = idx_q;
        rf_wr_data = wb_data_q;
    end

endmodule

// File: rtl/eagu_checker.sv
module eagu_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_valid,
    input logic [WORD_W-1:0] mem_addr,
    input logic              rf_wr_en,
    input logic              ind_err
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                        // R12
    AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && start |=> busy);                       // R12
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr)); // R13
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !done && !rf_wr_en);              // R14
    AST_WB_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> done && !mem_req);                         // R11
    AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ind_err |-> done && !mem_req);                          // R5

endmodule

bind ea_gen_unit eagu_checker #(.WORD_W(WORD_W)) u_eagu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .rf_wr_en  (rf_wr_en),
    .ind_err   (ind_err)
);

// File: tb/test_ea_gen_unit.sv
module test_ea_gen_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  spec_mode = '0;
    logic [2:0]  spec_reg = '0;
    logic        spec_auto = 1'b0;
    logic [15:0] spec_field = '0;
    logic [15:0] pc = 16'h0200;
    logic [15:0] sp_value = 16'h2000;
    logic [2:0]  rf_rd_idx;
    logic [15:0] rf_rd_data;
    logic        rf_wr_en;
    logic [2:0]  rf_wr_idx;
    logic [15:0] rf_wr_data;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        done;
    logic [15:0] ea;
    logic [15:0] operand;
    logic        ind_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int lat_sel = 0;
    int wait_cnt = 0;

    logic [15:0] regs [8];
    logic [15:0] mem_tab [logic [15:0]];
    logic [15:0] exp_q [$];

    always #10 clk = ~clk;

    assign rf_rd_data = regs[rf_rd_idx];

    ea_gen_unit i_ea_gen_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .spec_mode(spec_mode),
        .spec_reg(spec_reg), .spec_auto(spec_auto), .spec_field(spec_field),
        .pc(pc), .sp_value(sp_value), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .done(done), .ea(ea), .operand(operand),
        .ind_err(ind_err)
    );

    function automatic logic [15:0] mem_rd(logic [15:0] a);
        if (mem_tab.exists(a)) return mem_tab[a];
        return (a ^ 16'h2D5B) & 16'h7FFF;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // memory responder and per-cycle address comparison (R13)
    always @(negedge clk) begin
        cycles++;
        if (mem_valid) begin
            mem_valid <= 1'b0;
        end else if (rst_n && mem_req) begin
            if (wait_cnt > 0) begin
                wait_cnt--;
            end else begin
                if (exp_q.size() == 0) begin
                    check("R13 unexpected read", {16'h0, mem_addr}, 32'hFFFF_FFFF);
                end else begin
                    check("R13 read address", {16'h0, mem_addr}, {16'h0, exp_q[0]});
                    void'(exp_q.pop_front());
                end
                mem_valid <= 1'b1;
                mem_rdata <= mem_rd(mem_addr);
                lat_sel   = (lat_sel + 1) % 3;
                wait_cnt  = lat_sel;
            end
        end
    end

    always @(negedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    task automatic run_op(string tag, logic [2:0] md, logic [2:0] ri, logic au,
                          logic [15:0] fld, bit poke);
        logic [15:0] e_ea, e_op, addr, w;
        logic        e_err, e_wb;
        int          n;
        bit          seen;
        e_ea = '0; e_op = '0; e_err = 1'b0;
        exp_q.delete();
        unique case (md)
            3'd0: e_op = fld;
            3'd1: e_ea = fld;
            3'd2: begin
                addr = fld;
                for (int lv = 1; lv <= 4; lv++) begin
                    exp_q.push_back(addr);
                    w = mem_rd(addr);
                    if (!w[15]) begin e_ea = w; break; end
                    if (lv == 4) e_err = 1'b1;
                    addr = w & 16'h7FFF;
                end
            end
            3'd3: e_op = regs[ri];
            3'd4: e_ea = regs[ri];
            3'd5: e_ea = fld + regs[ri];
            3'd6: e_ea = fld + pc;
            default: e_ea = sp_value;
        endcase
        if (md != 3'd0 && md != 3'd3 && !e_err) begin
            exp_q.push_back(e_ea);
            e_op = mem_rd(e_ea);
        end
        e_wb = au && (md == 3'd4 || md == 3'd5);

        @(negedge clk);
        spec_mode = md; spec_reg = ri; spec_auto = au; spec_field = fld; start = 1'b1;
        @(negedge clk);
        if (poke) begin
            spec_mode = 3'd0; spec_field = 16'hBEEF; spec_auto = 1'b1;
        end else begin
            start = 1'b0;
        end
        n = 0; seen = 0;
        while (n < 300 && !seen) begin
            if (done) seen = 1;
            else begin
                @(negedge clk);
                start = 1'b0;
                n++;
            end
        end
        check({tag, " done seen"}, {31'h0, seen}, 32'h1);
        check({tag, " ea"}, {16'h0, ea}, {16'h0, e_ea});
        check({tag, " operand"}, {16'h0, operand}, {16'h0, e_op});
        check({tag, " R5 error flag"}, {31'h0, ind_err}, {31'h0, e_err});
        check({tag, " read count"}, exp_q.size(), 32'h0);
        check({tag, " R11 write strobe"}, {31'h0, rf_wr_en}, {31'h0, e_wb});
        if (e_wb) begin
            check({tag, " R11 write data"}, {16'h0, rf_wr_data}, {16'h0, regs[ri] + 16'h1});
            check({tag, " R11 write index"}, {29'h0, rf_wr_idx}, {29'h0, ri});
            regs[ri] = regs[ri] + 16'h1;
        end
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check({tag, " R12 no extra done"}, {31'h0, done}, 32'h0);
            check({tag, " R12 no extra read"}, {31'h0, mem_req}, 32'h0);
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 16'h1000 * i[15:0] + 16'h0100;
        regs[3] = 16'hFFFF;
        mem_tab[16'h0050] = 16'h0300;
        mem_tab[16'h0060] = 16'h8070;
        mem_tab[16'h0070] = 16'h8080;
        mem_tab[16'h0080] = 16'h0400;
        mem_tab[16'h0090] = 16'h8091;
        mem_tab[16'h0091] = 16'h8092;
        mem_tab[16'h0092] = 16'h8093;
        mem_tab[16'h0093] = 16'h0500;
        mem_tab[16'h00A0] = 16'h80A1;
        mem_tab[16'h00A1] = 16'h80A2;
        mem_tab[16'h00A2] = 16'h80A3;
        mem_tab[16'h00A3] = 16'h80A4;
        mem_tab[16'h2000] = 16'hCAFE;

        repeat (3) @(negedge clk);
        check("R14 done after reset", {31'h0, done}, 32'h0);
        check("R14 req after reset", {31'h0, mem_req}, 32'h0);
        check("R14 write after reset", {31'h0, rf_wr_en}, 32'h0);
        check("R14 error after reset", {31'h0, ind_err}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_op("R1 literal", 3'd0, 3'd2, 1'b1, 16'h1234, 0);
        run_op("R6 register", 3'd3, 3'd2, 1'b1, 16'h0000, 0);
        run_op("R2 absolute", 3'd1, 3'd0, 1'b0, 16'h0040, 0);
        run_op("R3 indirect", 3'd2, 3'd0, 1'b0, 16'h0050, 0);
        run_op("R4 chain of 3", 3'd2, 3'd0, 1'b1, 16'h0060, 0);
        run_op("R4 chain of 4", 3'd2, 3'd0, 1'b0, 16'h0090, 0);
        run_op("R5 depth overflow", 3'd2, 3'd0, 1'b0, 16'h00A0, 0);
        run_op("R7 reg pointer", 3'd4, 3'd1, 1'b1, 16'h0000, 0);
        run_op("R7 reg pointer again", 3'd4, 3'd1, 1'b0, 16'h0000, 0);
        run_op("R8 offset wrap", 3'd5, 3'd3, 1'b1, 16'h0005, 0);
        run_op("R8 offset after inc", 3'd5, 3'd3, 1'b0, 16'h0005, 0);
        pc = 16'hFFF0;
        run_op("R9 pc relative wrap", 3'd6, 3'd0, 1'b1, 16'h0020, 0);
        run_op("R10 stack top", 3'd7, 3'd0, 1'b1, 16'h0000, 0);
        run_op("R12 start while busy", 3'd1, 3'd0, 1'b0, 16'h0777, 1);
        run_op("R12 start while busy indirect", 3'd2, 3'd0, 1'b0, 16'h0060, 1);

        finish_run();
    end

endmodule